// File: doc/BRIEF.md
# Linear/Interleaved Burst Address Generator

This block produces the address sequence for a short memory burst. A full start address and an access type are captured on a load cycle. On each later advance cycle the low offset bits step through a four-beat pattern, while the upper address bits keep their loaded value. Two patterns are available: a linear count that adds one and wraps, and an interleaved order that XORs the start offset with a running beat number.

Advance cycles ignore the chip select and the write request. The read/write type chosen at load stays in force for the whole burst. An active-low clock enable freezes every register in the block. After reset the block is idle. An advance while idle does not start a burst, and a load with the chip deselected ends the current burst.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted, and after it is released, `valid` is 0, `addr` is all zeros and `is_write` is 0 until the first load.
- R2: A qualified edge (`clk_en_n`=0) with `advance`=0 and `chip_sel`=1 loads the burst. After that edge, `addr` equals `start_addr`, `valid` is 1, `is_write` equals `wr_en`, and the beat number restarts at 0.
- R3: A qualified edge with `advance`=0 and `chip_sel`=0 clears `valid` to 0.
- R4: With `seq_mode`=0 at load (linear), after n advances the low two address bits equal (start offset + n) mod 4.
- R5: With `seq_mode`=1 at load (interleaved), after n advances the low two address bits equal start offset XOR (n mod 4). For example, start 01 gives 01, 00, 11, 10.
- R6: After four advances the low two bits return to the start offset in either order. The sequence then repeats.
- R7: Address bits above bit 1 stay at their loaded value for every beat of a burst.
- R8: During advance edges `chip_sel` and `wr_en` have no effect: `valid` stays 1, and `is_write` keeps the value captured at load.
- R9: While `clk_en_n`=1, an edge changes none of `addr`, `valid` or `is_write`, whatever the other inputs are.
- R10: A qualified advance edge while `valid`=0 leaves `valid` at 0.
- R11: The order is captured at load. Changing `seq_mode` during a burst does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously inside |
| clk_en_n | input | 1 | Active-low clock qualifier; 1 holds all state |
| advance | input | 1 | 1 = step the burst, 0 = load or deselect |
| chip_sel | input | 1 | Combined chip select, active high, used only on load/deselect edges |
| seq_mode | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| wr_en | input | 1 | Access type at load: 1 write, 0 read |
| start_addr | input | ADDR_W | Burst start address |
| addr | output | ADDR_W | Current burst address |
| is_write | output | 1 | Access type latched at load |
| valid | output | 1 | A burst is active |

## Verification
The bench builds the block with ADDR_W = 6, so all 64 start addresses can be swept in both orders and both access types. Each burst runs five beats, which crosses the wrap point. During the beats the bench toggles the chip select, the write request and the mode input, and it inserts a held clock-enable cycle mid-burst. Expected offsets are computed from the modular-add and XOR rules. Every burst ends with a deselect and an idle advance.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic {
    ORDER_LINEAR = 1'b0,
    ORDER_XOR    = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_LOAD  = 2'd1,
    CMD_STEP  = 2'd2,
    CMD_DESEL = 2'd3
  } cmd_e;

endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
  import burst_pkg::*;
(
  input  logic clk_en_n,
  input  logic advance,
  input  logic chip_sel,
  input  logic active,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_HOLD;
    if (!clk_en_n) begin
      if (advance) begin
        // Chip select is not consulted while stepping.
        cmd = active ? CMD_STEP : CMD_HOLD;
      end else begin
        cmd = chip_sel ? CMD_LOAD : CMD_DESEL;
      end
    end
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
#(
  parameter int unsigned OFF_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  output logic [OFF_W-1:0] beat
);

  logic [OFF_W-1:0] beat_q;
  logic [OFF_W-1:0] beat_d;

  always_comb begin
    beat_d = beat_q;
    case (cmd)
      CMD_LOAD: beat_d = '0;
      CMD_STEP: beat_d = beat_q + OFF_W'(1);
      default:  beat_d = beat_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beat_q <= '0;
    else        beat_q <= beat_d;
  end

  assign beat = beat_q;

  AST_BEAT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LOAD) |=> (beat == '0)); // R2

endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
  import burst_pkg::*;
#(
  parameter int unsigned OFF_W = 2
) (
  input  order_e           order,
  input  logic [OFF_W-1:0] start_off,
  input  logic [OFF_W-1:0] beat,
  output logic [OFF_W-1:0] off
);

  logic [OFF_W-1:0] lin_off;
  logic [OFF_W-1:0] xor_off;

  assign lin_off = start_off + beat;
  assign xor_off = start_off ^ beat;

  always_comb begin
    off = (order == ORDER_XOR) ? xor_off : lin_off;
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W    = 20,
  parameter int unsigned BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              advance,
  input  logic              chip_sel,
  input  logic              seq_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W-1:0] addr,
  output logic              is_write,
  output logic              valid
);

  localparam int unsigned OFF_W = $clog2(BURST_LEN);

  // Reset: asynchronous assertion, two-stage synchronous release.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end

  assign rst_sync_n = rst_pipe_q[1];

  cmd_e             cmd;
  logic [ADDR_W-1:0] base_q, base_d;
  order_e            order_q, order_d;
  logic              wr_q, wr_d;
  logic              valid_q, valid_d;
  logic [OFF_W-1:0]  beat;
  logic [OFF_W-1:0]  off;

  burst_cmd_dec u_cmd_dec (
    .clk_en_n (clk_en_n),
    .advance  (advance),
    .chip_sel (chip_sel),
    .active   (valid_q),
    .cmd      (cmd)
  );

  burst_beat_ctr #(.OFF_W(OFF_W)) u_beat_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .cmd   (cmd),
    .beat  (beat)
  );

  burst_offset_map #(.OFF_W(OFF_W)) u_offset_map (
    .order     (order_q),
    .start_off (base_q[OFF_W-1:0]),
    .beat      (beat),
    .off       (off)
  );

  always_comb begin
    base_d  = base_q;
    order_d = order_q;
    wr_d    = wr_q;
    valid_d = valid_q;
    case (cmd)
      CMD_LOAD: begin
        base_d  = start_addr;
        order_d = order_e'(seq_mode);
        wr_d    = wr_en;
        valid_d = 1'b1;
      end
      CMD_DESEL: valid_d = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      base_q  <= '0;
      order_q <= ORDER_LINEAR;
      wr_q    <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      base_q  <= base_d;
      order_q <= order_d;
      wr_q    <= wr_d;
      valid_q <= valid_d;
    end
  end

  assign addr     = {base_q[ADDR_W-1:OFF_W], off};
  assign is_write = wr_q;
  assign valid    = valid_q;

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clk_en_n |=> ($stable(addr) && $stable(is_write) && $stable(valid))); // R9

  AST_ADV_KEEPS_TYPE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clk_en_n && advance) |=> ($stable(is_write) && $stable(valid))); // R8

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clk_en_n && advance) |=> $stable(addr[ADDR_W-1:OFF_W])); // R7

  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clk_en_n && advance && valid && order_q == ORDER_LINEAR)
      |=> (addr[OFF_W-1:0] == OFF_W'($past(addr[OFF_W-1:0]) + OFF_W'(1)))); // R4

  AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clk_en_n && advance && !valid) |=> !valid); // R10

  AST_DESEL_ENDS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!clk_en_n && !advance && !chip_sel) |=> !valid); // R3

endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  localparam int unsigned AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          clk_en_n;
  logic          advance;
  logic          chip_sel;
  logic          seq_mode;
  logic          wr_en;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] addr;
  logic          is_write;
  logic          valid;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BURST_LEN(4)) i_burst_addr_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en_n   (clk_en_n),
    .advance    (advance),
    .chip_sel   (chip_sel),
    .seq_mode   (seq_mode),
    .wr_en      (wr_en),
    .start_addr (start_addr),
    .addr       (addr),
    .is_write   (is_write),
    .valid      (valid)
  );

  task automatic check(string req, logic [AW-1:0] ea, logic ev, logic ew);
    n_cmp++;
    if (addr !== ea || valid !== ev || is_write !== ew) begin
      n_bad++;
      $display("FAIL %s: addr=%h valid=%b wr=%b expected addr=%h valid=%b wr=%b",
               req, addr, valid, is_write, ea, ev, ew);
    end
  endtask

  task automatic check_valid(string req, logic ev);
    n_cmp++;
    if (valid !== ev) begin
      n_bad++;
      $display("FAIL %s: valid=%b expected %b", req, valid, ev);
    end
  endtask

  task automatic edge_drive(logic ce_n, logic adv, logic cs, logic md, logic we,
                            logic [AW-1:0] sa);
    @(negedge clk);
    clk_en_n = ce_n; advance = adv; chip_sel = cs;
    seq_mode = md; wr_en = we; start_addr = sa;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] exp_off(logic md, logic [1:0] s, int n);
    logic [1:0] b;
    b = 2'(n % 4);
    return md ? (s ^ b) : 2'(s + b);
  endfunction

  initial begin : watchdog
    #1600000;
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    logic [AW-1:0] hold_addr;
    rst_n = 1'b0; clk_en_n = 1'b1; advance = 1'b0; chip_sel = 1'b0;
    seq_mode = 1'b0; wr_en = 1'b0; start_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", '0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 after release", '0, 1'b0, 1'b0);
    // R10: advance before any load
    edge_drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 6'h2a);
    check("R10 idle advance", '0, 1'b0, 1'b0);

    for (int md = 0; md < 2; md++) begin
      for (int we = 0; we < 2; we++) begin
        for (int sa = 0; sa < 64; sa++) begin
          logic [AW-1:0] s;
          s = AW'(sa);
          // R2: load
          edge_drive(1'b0, 1'b0, 1'b1, md[0], we[0], s);
          check("R2 load", s, 1'b1, we[0]);
          for (int n = 1; n <= 5; n++) begin
            // R8/R11: scramble chip select, write request and mode during advance
            edge_drive(1'b0, 1'b1, n[0], ~md[0] ^ n[1], ~we[0], ~s);
            hold_addr = {s[AW-1:2], exp_off(md[0], s[1:0], n)};
            if (n == 4)
              check("R6 wrap to start", s, 1'b1, we[0]);
            else if (md == 0)
              check("R4 linear beat / R7 R8 R11", hold_addr, 1'b1, we[0]);
            else
              check("R5 interleaved beat / R7 R8 R11", hold_addr, 1'b1, we[0]);
            if (n == 2) begin
              // R9: stalled edge with every other input active
              edge_drive(1'b1, 1'b0, 1'b0, ~md[0], ~we[0], ~s);
              check("R9 stall hold", hold_addr, 1'b1, we[0]);
            end
          end
          // R3: deselect
          edge_drive(1'b0, 1'b0, 1'b0, md[0], we[0], s);
          check_valid("R3 deselect", 1'b0);
          // R10: advance while idle
          edge_drive(1'b0, 1'b1, 1'b1, md[0], we[0], s);
          check_valid("R10 idle advance", 1'b0);
        end
      end
    end

    // R5 named example: start offset 01 interleaved -> 01,00,11,10
    edge_drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 6'h05);
    check("R5 example beat0", 6'h05, 1'b1, 1'b0);
    edge_drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'h00);
    check("R5 example beat1", 6'h04, 1'b1, 1'b0);
    edge_drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'h00);
    check("R5 example beat2", 6'h07, 1'b1, 1'b0);
    edge_drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 6'h00);
    check("R5 example beat3", 6'h06, 1'b1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule